// File: doc/BRIEF.md
# Serial Programming Slave Port

This block is the target end of a four-byte serial programming link. An external programmer drives a serial clock and a data-in line while it holds the target's programming reset input low. The block oversamples both lines with its own system clock, frames the bits into four-byte instructions (most significant bit first), and turns each valid instruction into a single-cycle request on a memory request port. The core side behind that port owns the program memory, the byte-wide non-volatile data memory, the fuse, lock and signature storage.

Nothing is forwarded until the enable instruction `0xAC 0x53 x x` has been framed after programming mode was entered. While the third byte of any instruction is shifting in, the data-out line returns the second byte. For the enable instruction that byte is `0x53`, so the programmer can check that it is still in step with the target. Read instructions request their data once the third byte has arrived and return it while the fourth byte is shifted. Write-type instructions are issued after the fourth byte.

Top module: `spi_prog_target`

## Requirements
- R1: While `rst_n` is low, or while `prog_rst_n` has been high for two or more system cycles, `miso` is 0 and `req_valid` is 0.
- R2: Data-in is taken on rising serial-clock edges, most significant bit first. Data-out changes only in the system cycle after a detected falling serial-clock edge.
- R3: The instruction `0xAC 0x53 x x` enables the block. While its third byte is shifted, `miso` carries `0x53`.
- R4: During byte 1 the data-out line carries the fourth byte of the previous instruction (0 after mode entry). During bytes 2 and 3 it carries the byte received just before. During byte 4 it carries byte 3, except for an enabled read.
- R5: Before enable, no instruction issues a request.
- R6: An enabled read issues one request when byte 3 completes, with `req_addr` = {byte2, byte3} and `req_data` = 0. The core returns `rd_data` one cycle after `req_valid`. That value is shifted out during byte 4.
- R7: An enabled write or load issues one request when byte 4 completes, with `req_addr` = {byte2, byte3} and `req_data` = byte 4.
- R8: Op codes on `req_op`:
  - 1: erase, `0xAC` with byte2[7:1]=`0x40`
  - 2: program read, `0x20`/`0x28`
  - 3: program load, `0x40`/`0x48`
  - 4: program page write, `0x4C`
  - 5: data read, `0xA0`
  - 6: data byte write, `0xC0`
  - 7: data page load, `0xC1`
  - 8: data page write, `0xC2`
  - 9: lock read, `0x58 0x00`
  - 10: lock write, `0xAC` with byte2[7:5]=`111`
  - 11: signature read, `0x30`
  - 12/13/14: fuse low/high/extended, `0xAC 0xA0`/`0xA8`/`0xA4`

  `req_hi` = byte1[3] for op codes 2 and 3, and 0 otherwise.
- R9: A program high-byte load is forwarded only when the most recent program load was a forwarded low-byte load with the same byte 3. Any high-byte load clears that pairing.
- R10: Raising `prog_rst_n` discards a partly framed instruction and clears the enable and the pairing. Programming must be re-enabled afterwards.
- R11: `req_valid` is never high for two consecutive cycles.
- R12: Unrecognised instructions, including a repeated enable, issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_rst_n | input | 1 | Programming reset; low selects programming mode |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| req_valid | output | 1 | Single-cycle request strobe |
| req_op | output | 4 | Request op code (R8) |
| req_hi | output | 1 | High-byte select for program read and load |
| req_addr | output | 16 | {byte2, byte3} of the instruction |
| req_data | output | 8 | Byte 4 for writes, 0 for reads |
| rd_data | input | 8 | Read result, valid one cycle after `req_valid` |

## Verification
A read request appears a few system cycles after the rising serial-clock edge of the last bit of byte 3: two synchroniser stages plus one register. A write request appears at the same distance after the last bit of byte 4. The bench predicts every request in an ordered queue and compares `req_valid` on each falling system-clock edge, so an unpredicted or early request is caught in the cycle it occurs. `miso` follows a falling serial edge after about three system cycles. The bench holds each serial phase for six system cycles and reads `miso` just before it raises the serial clock, so each expected bit has settled by the time it is sampled. This includes the `0x53` echo and the read data, which is ready well before byte 4 starts.

// File: rtl/spi_prog_target.sv
module spi_prog_target #(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_rst_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  output logic        req_valid,
  output logic [3:0]  req_op,
  output logic        req_hi,
  output logic [15:0] req_addr,
  output logic [7:0]  req_data,
  input  logic [7:0]  rd_data
);
  localparam logic [3:0] OP_NONE = 4'd0, OP_ERASE = 4'd1, OP_RD_PROG = 4'd2,
    OP_LD_PROG = 4'd3, OP_WR_PROG = 4'd4, OP_RD_EE = 4'd5, OP_WR_EE = 4'd6,
    OP_LD_EE = 4'd7, OP_WR_EE_PG = 4'd8, OP_RD_LOCK = 4'd9, OP_WR_LOCK = 4'd10,
    OP_RD_SIG = 4'd11, OP_FUSE_LO = 4'd12, OP_FUSE_HI = 4'd13, OP_FUSE_EXT = 4'd14;

  function automatic logic [3:0] rd_op(input logic [7:0] a, input logic [7:0] b);
    case (a)
      8'h20, 8'h28: rd_op = OP_RD_PROG;
      8'hA0:        rd_op = OP_RD_EE;
      8'h30:        rd_op = OP_RD_SIG;
      8'h58:        rd_op = (b == 8'h00) ? OP_RD_LOCK : OP_NONE;
      default:      rd_op = OP_NONE;
    endcase
  endfunction

  function automatic logic [3:0] wr_op(input logic [7:0] a, input logic [7:0] b);
    wr_op = OP_NONE;
    case (a)
      8'hAC: begin
        if (b[7:1] == 7'h40)       wr_op = OP_ERASE;
        else if (b[7:5] == 3'b111) wr_op = OP_WR_LOCK;
        else if (b == 8'hA0)       wr_op = OP_FUSE_LO;
        else if (b == 8'hA8)       wr_op = OP_FUSE_HI;
        else if (b == 8'hA4)       wr_op = OP_FUSE_EXT;
      end
      8'h40, 8'h48: wr_op = OP_LD_PROG;
      8'h4C:        wr_op = OP_WR_PROG;
      8'hC0:        wr_op = OP_WR_EE;
      8'hC1:        wr_op = OP_LD_EE;
      8'hC2:        wr_op = OP_WR_EE_PG;
      default:      wr_op = OP_NONE;
    endcase
  endfunction

  logic [SYNC-1:0] sck_q, mosi_q, prst_q;
  logic            sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      prst_q <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[SYNC-2:0], sck};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      prst_q <= {prst_q[SYNC-2:0], prog_rst_n};
      sck_d  <= sck_q[SYNC-1];
    end

  wire mode = ~prst_q[SYNC-1];
  wire rise = mode &  sck_q[SYNC-1] & ~sck_d;
  wire fall = mode & ~sck_q[SYNC-1] &  sck_d;

  logic [2:0] bit_cnt;
  logic [1:0] byte_cnt;
  logic [6:0] sh;
  logic [7:0] b1, b2, b3, tx, nxt, lo_off;
  logic       enabled, lo_ok, req_rd, rd_wait;

  wire [7:0] byte_in   = {sh, mosi_q[SYNC-1]};
  wire       byte_done = rise && (bit_cnt == 3'd7);
  wire [3:0] rop       = rd_op(b1, b2);
  wire [3:0] wop       = wr_op(b1, b2);

  assign miso = tx[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; byte_cnt <= '0; sh <= '0;
      b1 <= '0; b2 <= '0; b3 <= '0; tx <= '0; nxt <= '0; lo_off <= '0;
      enabled <= 1'b0; lo_ok <= 1'b0; req_rd <= 1'b0; rd_wait <= 1'b0;
      req_valid <= 1'b0; req_op <= OP_NONE; req_hi <= 1'b0;
      req_addr <= '0; req_data <= '0;
    end else begin
      req_valid <= 1'b0;
      rd_wait   <= req_valid & req_rd;
      if (rd_wait) nxt <= rd_data;
      if (!mode) begin
        bit_cnt <= '0; byte_cnt <= '0; enabled <= 1'b0;
        tx <= '0; nxt <= '0; lo_ok <= 1'b0; rd_wait <= 1'b0;
      end else begin
        if (rise) begin
          sh      <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          byte_cnt <= byte_cnt + 2'd1;
          nxt      <= byte_in;
          case (byte_cnt)
            2'd0: b1 <= byte_in;
            2'd1: b2 <= byte_in;
            2'd2: begin
              b3 <= byte_in;
              if (enabled && rop != OP_NONE) begin
                req_valid <= 1'b1;
                req_rd    <= 1'b1;
                req_op    <= rop;
                req_hi    <= (rop == OP_RD_PROG) & b1[3];
                req_addr  <= {b2, byte_in};
                req_data  <= 8'h00;
              end
            end
            default: begin
              if (!enabled) begin
                enabled <= (b1 == 8'hAC) && (b2 == 8'h53);
              end else if (wop != OP_NONE) begin
                if (wop == OP_LD_PROG && b1[3]) lo_ok <= 1'b0;
                else if (wop == OP_LD_PROG) begin
                  lo_ok  <= 1'b1;
                  lo_off <= b3;
                end
                if (!(wop == OP_LD_PROG && b1[3] && !(lo_ok && lo_off == b3))) begin
                  req_valid <= 1'b1;
                  req_rd    <= 1'b0;
                  req_op    <= wop;
                  req_hi    <= (wop == OP_LD_PROG) & b1[3];
                  req_addr  <= {b2, b3};
                  req_data  <= byte_in;
                end
              end
            end
          endcase
        end
        if (fall) tx <= (bit_cnt == 3'd0) ? nxt : {tx[6:0], 1'b0};
      end
    end

  p_quiet_out_of_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !$past(mode)) |-> (!req_valid && !miso));

  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $past(mode) && !$stable(miso)) |-> $past(fall));

  p_no_req_before_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(enabled));

  p_hi_after_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_LD_PROG && req_hi) |-> ($past(lo_ok) && !lo_ok));

  p_exit_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode) |=> (bit_cnt == 3'd0 && byte_cnt == 2'd0 && !enabled && !lo_ok));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
endmodule

// File: tb/tb_spi_prog_target.sv
module tb_spi_prog_target;
  localparam int PH = 6;

  logic clk = 1'b0, rst_n = 1'b0, prog_rst_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, req_valid, req_hi;
  logic [3:0]  req_op;
  logic [15:0] req_addr;
  logic [7:0]  req_data;
  logic [7:0]  rd_data = 8'h00;

  always #5 clk = ~clk;

  spi_prog_target dut (
    .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
    .miso(miso), .req_valid(req_valid), .req_op(req_op), .req_hi(req_hi),
    .req_addr(req_addr), .req_data(req_data), .rd_data(rd_data));

  int compared = 0, mismatched = 0;
  logic [28:0] expq[$];
  bit m_en = 1'b0, m_lo = 1'b0;
  logic [7:0] m_off = 8'h00, m_prev = 8'h00;

  function automatic logic [7:0] core_val(input logic [3:0] op, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ {op, 4'h5};
  endfunction

  always @(posedge clk) if (req_valid) rd_data <= core_val(req_op, req_addr);

  task automatic chk(input bit ok, input string r, input logic [31:0] a, input logic [31:0] e);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  always @(negedge clk)
    if (rst_n && req_valid) begin
      if (expq.size() == 0) chk(1'b0, "R12 unexpected request", {3'b0, req_op, req_hi, req_addr, req_data}, 32'h0);
      else begin
        logic [28:0] e;
        e = expq.pop_front();
        chk({req_op, req_hi, req_addr, req_data} == e, "R8 request fields",
            {3'b0, req_op, req_hi, req_addr, req_data}, {3'b0, e});
      end
    end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      tick(PH);
      r[i] = miso;
      sck = 1'b1;
      tick(PH);
      sck = 1'b0;
    end
  endtask

  task automatic instr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, input string tag);
    logic [7:0] r1, r2, r3, r4, e4;
    logic [3:0] op;
    bit hi, is_rd;
    op = 4'd0; hi = 1'b0; is_rd = 1'b0; e4 = c;
    case (a)
      8'h20, 8'h28: begin op = 4'd2; hi = a[3]; is_rd = 1'b1; end
      8'hA0: begin op = 4'd5; is_rd = 1'b1; end
      8'h30: begin op = 4'd11; is_rd = 1'b1; end
      8'h58: if (b == 8'h00) begin op = 4'd9; is_rd = 1'b1; end
      8'hAC: begin
        if (b == 8'h80 || b == 8'h81) op = 4'd1;
        else if (b >= 8'hE0) op = 4'd10;
        else if (b == 8'hA0) op = 4'd12;
        else if (b == 8'hA8) op = 4'd13;
        else if (b == 8'hA4) op = 4'd14;
      end
      8'h40: op = 4'd3;
      8'h48: begin op = 4'd3; hi = 1'b1; end
      8'h4C: op = 4'd4;
      8'hC0: op = 4'd6;
      8'hC1: op = 4'd7;
      8'hC2: op = 4'd8;
      default: op = 4'd0;
    endcase
    if (m_en && op != 4'd0) begin
      if (is_rd) begin
        e4 = core_val(op, {b, c});
        expq.push_back({op, hi, b, c, 8'h00});
      end else if (op == 4'd3 && hi) begin
        if (m_lo && m_off == c) expq.push_back({op, 1'b1, b, c, d});
        m_lo = 1'b0;
      end else begin
        if (op == 4'd3) begin m_lo = 1'b1; m_off = c; end
        expq.push_back({op, 1'b0, b, c, d});
      end
    end
    xfer(a, r1); xfer(b, r2); xfer(c, r3); xfer(d, r4);
    chk(r1 == m_prev, {tag, " R4 byte1 echo"}, r1, m_prev);
    chk(r2 == a, {tag, " R4 byte2 echo"}, r2, a);
    chk(r3 == b, {tag, " R3 byte3 echo"}, r3, b);
    chk(r4 == e4, {tag, " R6 byte4"}, r4, e4);
    if (!m_en && a == 8'hAC && b == 8'h53) m_en = 1'b1;
    m_prev = d;
    tick(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    tick(4);
    chk(miso == 1'b0 && req_valid == 1'b0, "R1 reset state", {miso, req_valid}, 0);
    rst_n = 1'b1;
    tick(4);
    chk(miso == 1'b0 && req_valid == 1'b0, "R1 out of mode", {miso, req_valid}, 0);
    prog_rst_n = 1'b0;
    tick(10);
    instr(8'h20, 8'h00, 8'h05, 8'h00, "R5 read before enable");
    instr(8'hC0, 8'h00, 8'h10, 8'h77, "R5 write before enable");
    instr(8'hAC, 8'h53, 8'h00, 8'h00, "R3 enable");
    instr(8'h20, 8'h01, 8'h23, 8'h00, "R6 program low read");
    instr(8'h28, 8'h01, 8'h23, 8'h00, "R6 program high read");
    instr(8'hA0, 8'h00, 8'h3F, 8'h00, "R6 data read");
    instr(8'h30, 8'h00, 8'h02, 8'h00, "R6 signature");
    instr(8'h58, 8'h00, 8'h00, 8'h00, "R6 lock read");
    instr(8'hAC, 8'h80, 8'h00, 8'h00, "R7 erase");
    instr(8'h40, 8'h00, 8'h05, 8'hAA, "R9 low load");
    instr(8'h48, 8'h00, 8'h05, 8'hBB, "R9 paired high");
    instr(8'h48, 8'h00, 8'h05, 8'hBC, "R9 repeat high dropped");
    instr(8'h40, 8'h00, 8'h06, 8'h11, "R9 low load");
    instr(8'h48, 8'h00, 8'h07, 8'hCC, "R9 mismatched high dropped");
    instr(8'h4C, 8'h00, 8'h40, 8'h00, "R7 program page write");
    instr(8'hC0, 8'h00, 8'h10, 8'h55, "R7 data byte write");
    instr(8'hC1, 8'h00, 8'h02, 8'h66, "R7 data page load");
    instr(8'hC2, 8'h00, 8'h0C, 8'h00, "R7 data page write");
    instr(8'hAC, 8'hE0, 8'h00, 8'hFC, "R8 lock write");
    instr(8'hAC, 8'hA0, 8'h00, 8'h62, "R8 fuse low");
    instr(8'hAC, 8'hA8, 8'h00, 8'hDF, "R8 fuse high");
    instr(8'hAC, 8'hA4, 8'h00, 8'hFF, "R8 fuse ext");
    instr(8'hFF, 8'h12, 8'h34, 8'h56, "R12 unknown");
    instr(8'hAC, 8'h53, 8'h00, 8'h00, "R12 repeat enable");
    instr(8'h40, 8'h00, 8'h09, 8'h21, "R10 low load before exit");
    xfer(8'h20, junk); xfer(8'h00, junk);
    prog_rst_n = 1'b1;
    tick(10);
    chk(miso == 1'b0 && req_valid == 1'b0, "R10 exit idle", {miso, req_valid}, 0);
    prog_rst_n = 1'b0;
    tick(10);
    m_en = 1'b0; m_lo = 1'b0; m_prev = 8'h00;
    instr(8'h20, 8'h00, 8'h05, 8'h00, "R10 read needs re-enable");
    instr(8'hAC, 8'h53, 8'h11, 8'h22, "R10 re-enable");
    instr(8'h48, 8'h00, 8'h09, 8'h31, "R10 pairing cleared");
    instr(8'hA0, 8'h01, 8'hFE, 8'h00, "R6 read after re-enable");
    tick(20);
    chk(expq.size() == 0, "R7 all requests seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule